// File: doc/BRIEF.md
# Clock Second-Chance Victim Scanner

This block picks which page frame to give up when a new page must be loaded. It keeps one "recently used" flag for each frame in a circular set. The access port raises a frame's flag whenever that frame is touched. A hand pointer keeps its position between requests. It moves only while an eviction is being served.

When an eviction is requested, the hand looks at one frame per clock cycle. If the frame's flag is raised, the flag is lowered and the frame is passed over. This gives a recently used frame a second chance. The first frame found with its flag lowered is reported as the victim, and the hand stops on the frame after it. If every flag is raised, one full turn lowers all of them and the frame where the turn began is chosen. In that case the policy acts as first-in first-out.

Loading the new page and managing memory contents are left to the logic around the block. That logic raises the victim's flag through the access port once the frame is filled again.

Top module: `clock_victim_scan`

## Requirements
- R1: Each frame has exactly one reference flag. A cycle with `acc_valid` high raises the flag of the frame whose binary index (0 to NUM_FRAMES-1) is on `acc_frame`.
- R2: After reset every flag is low, the hand is on frame 0, and `busy` and `victim_valid` are low.
- R3: Without an accepted request the scanner stays idle and `busy` stays low. A request raises `busy` in the next cycle. `busy` stays high until the cycle in which `victim_valid` is high, and is low in that cycle.
- R4: The scanner examines one frame per cycle. The victim is reported k+1 cycles after the request is accepted, where k is the number of frames passed over.
- R5: A frame at the hand with its flag low becomes the victim. A frame at the hand with its flag high has its flag lowered and is passed over.
- R6: The hand moves in increasing index order and wraps from frame NUM_FRAMES-1 to frame 0.
- R7: If every flag is high, the scan lowers all of them in one full turn and chooses the frame where the scan began, after NUM_FRAMES+1 cycles.
- R8: After a victim is reported, the hand rests on the frame that follows the victim, so the next scan starts there.
- R9: If an access hits the frame whose flag the scan lowers in the same cycle, the flag stays high.
- R10: `evict_req` while `busy` is high is ignored. It causes neither an extra victim nor a longer scan.
- R11: `victim_valid` is high for exactly one cycle for each accepted request, and `victim_frame` carries the victim's index in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A frame was referenced this cycle |
| acc_frame | input | IDX_W | Index of the referenced frame |
| evict_req | input | 1 | Request for a victim frame |
| victim_valid | output | 1 | One-cycle pulse: victim index is valid |
| victim_frame | output | IDX_W | Index of the chosen victim |
| busy | output | 1 | Scan in progress |

## Verification
The hardest case to reach from the ports is an access that lands on the very frame whose flag the hand is lowering in that cycle. It has to hit an exact cycle in the middle of a scan. The bench raises every flag so the scan runs a full, predictable turn. It counts cycles from the request and drives the access in the cycle when the hand sits two frames past its start. Two follow-up evictions then show, through the victims they report, that the flag stayed high. A long sweep over many flag patterns, at hand positions that move on with each eviction, compares each victim and each latency with an arithmetic model.

// File: rtl/clock_victim_scan_pkg.sv
package clock_victim_scan_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;
endpackage

// File: rtl/clock_victim_refbits.sv
// One reference flag per frame; a set request beats a clear request on the same frame.
module clock_victim_refbits #(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set_valid,
  input  logic [IDX_W-1:0]      set_idx,
  input  logic                  clr_valid,
  input  logic [IDX_W-1:0]      clr_idx,
  output logic [NUM_FRAMES-1:0] bits
);
  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    logic set_hit, clr_hit, bit_en, bit_d, bit_q;

    always_comb begin
      set_hit = set_valid && (set_idx == IDX_W'(g));
      clr_hit = clr_valid && (clr_idx == IDX_W'(g));
      bit_en  = set_hit || clr_hit;
      bit_d   = set_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else if (bit_en) begin
        bit_q <= bit_d;
      end
    end

    assign bits[g] = bit_q;
  end
endmodule

// File: rtl/clock_victim_hand.sv
// Circular hand pointer, wraps at the last frame.
module clock_victim_hand #(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] hand
);
  logic [IDX_W-1:0] hand_d, hand_q;

  always_comb begin
    if (hand_q == LAST_IDX) begin
      hand_d = '0;
    end else begin
      hand_d = hand_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hand_q <= '0;
    end else if (advance) begin
      hand_q <= hand_d;
    end
  end

  assign hand = hand_q;
endmodule

// File: rtl/clock_victim_ctrl.sv
// Scan sequencer: idle until a request, then one frame per cycle until a victim is found.
module clock_victim_ctrl
  import clock_victim_scan_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evict_req,
  input  logic             cur_bit,
  input  logic [IDX_W-1:0] hand,
  output logic             scanning,
  output logic             skip,
  output logic             take,
  output logic             victim_valid,
  output logic [IDX_W-1:0] victim_frame
);
  scan_state_e state_q, state_d;
  logic             vv_d, vv_q;
  logic [IDX_W-1:0] vf_q;

  always_comb begin
    scanning = (state_q == SCAN_RUN);
    skip     = scanning && cur_bit;
    take     = scanning && !cur_bit;
    state_d  = state_q;
    case (state_q)
      SCAN_IDLE: if (evict_req) state_d = SCAN_RUN;
      SCAN_RUN:  if (take)      state_d = SCAN_IDLE;
      default:                  state_d = SCAN_IDLE;
    endcase
    vv_d = take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      vv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      vv_q    <= vv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vf_q <= '0;
    end else if (take) begin
      vf_q <= hand;
    end
  end

  assign victim_valid = vv_q;
  assign victim_frame = vf_q;
endmodule

// File: rtl/clock_victim_scan.sv
module clock_victim_scan #(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_frame,
  input  logic             evict_req,
  output logic             victim_valid,
  output logic [IDX_W-1:0] victim_frame,
  output logic             busy
);
  logic [NUM_FRAMES-1:0] ref_bits;
  logic [IDX_W-1:0]      hand_q;
  logic                  cur_bit, scanning, skip, take;

  assign cur_bit = ref_bits[hand_q];
  assign busy    = scanning;

  clock_victim_refbits #(.NUM_FRAMES(NUM_FRAMES)) refbits_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_valid(acc_valid),
    .set_idx  (acc_frame),
    .clr_valid(skip),
    .clr_idx  (hand_q),
    .bits     (ref_bits)
  );

  clock_victim_hand #(.NUM_FRAMES(NUM_FRAMES)) hand_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(skip || take),
    .hand   (hand_q)
  );

  clock_victim_ctrl #(.NUM_FRAMES(NUM_FRAMES)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .evict_req   (evict_req),
    .cur_bit     (cur_bit),
    .hand        (hand_q),
    .scanning    (scanning),
    .skip        (skip),
    .take        (take),
    .victim_valid(victim_valid),
    .victim_frame(victim_frame)
  );
endmodule

// File: rtl/clock_victim_scan_chk.sv
module clock_victim_scan_chk #(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  acc_valid,
  input logic [IDX_W-1:0]      acc_frame,
  input logic                  evict_req,
  input logic                  victim_valid,
  input logic [IDX_W-1:0]      victim_frame,
  input logic                  busy,
  input logic [NUM_FRAMES-1:0] ref_bits,
  input logic [IDX_W-1:0]      hand_q
);
  // R1, R9: an access always leaves its flag high, even against a scan clear
  p_access_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> ref_bits[$past(acc_frame)]);

  // R3: idle without request stays idle
  p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !evict_req) |=> !busy);

  // R3: accepted request starts a scan
  p_req_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && evict_req) |=> busy);

  // R3: busy is low while the victim is reported, and a scan preceded it
  p_victim_after_scan_r3: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> (!busy && $past(busy)));

  // R11: one-cycle pulse
  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |=> !victim_valid);

  // R5: victim flag was low (unless raised by an access on the same edge)
  p_victim_flag_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_valid && !$past(acc_valid && (acc_frame == victim_frame)))
      |-> !ref_bits[victim_frame]);

  // R8, R6: hand rests just past the victim, wrapping at the end
  p_hand_after_victim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> (hand_q == ((victim_frame == LAST_IDX) ? '0 : victim_frame + IDX_W'(1))));

  // R10: hand does not move while idle
  p_hand_still_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(hand_q));
endmodule

bind clock_victim_scan clock_victim_scan_chk #(.NUM_FRAMES(NUM_FRAMES)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_frame   (acc_frame),
  .evict_req   (evict_req),
  .victim_valid(victim_valid),
  .victim_frame(victim_frame),
  .busy        (busy),
  .ref_bits    (ref_bits),
  .hand_q      (hand_q)
);

// File: tb/clock_victim_scan_tb_top.sv
`timescale 1ns/1ps
module clock_victim_scan_tb_top;
  localparam int N = 8;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [W-1:0] acc_frame = '0;
  logic evict_req = 1'b0;
  logic victim_valid;
  logic [W-1:0] victim_frame;
  logic busy;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  bit m_bits [N];
  int m_hand;

  always #4 clk = ~clk;

  clock_victim_scan #(.NUM_FRAMES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
    .evict_req(evict_req), .victim_valid(victim_valid),
    .victim_frame(victim_frame), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic touch(input int f);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_frame = W'(f);
    m_bits[f] = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic start_evict();
    @(negedge clk);
    evict_req = 1'b1;
    @(negedge clk);
    evict_req = 1'b0;
    chk(busy == 1'b1, "R3 busy after request", int'(busy), 1);
  endtask

  task automatic wait_victim(output int fr, output int lat, output bit busy_ok);
    lat = 0;
    busy_ok = 1'b1;
    while (!victim_valid && lat < 4 * N) begin
      if (!busy) busy_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    fr = int'(victim_frame);
    if (busy) busy_ok = 1'b0;
  endtask

  task automatic model_evict(output int v, output int skips, output bit wrapped);
    skips = 0;
    wrapped = 1'b0;
    while (m_bits[m_hand]) begin
      m_bits[m_hand] = 1'b0;
      if (m_hand == N - 1) wrapped = 1'b1;
      m_hand = (m_hand + 1) % N;
      skips++;
    end
    v = m_hand;
    if (m_hand == N - 1) wrapped = 1'b1;
    m_hand = (m_hand + 1) % N;
  endtask

  task automatic evict_and_check(input string tag);
    int ev, sk, fr, lat;
    bit wr, bok;
    bit all_set = 1'b1;
    for (int i = 0; i < N; i++) if (!m_bits[i]) all_set = 1'b0;
    model_evict(ev, sk, wr);
    start_evict();
    wait_victim(fr, lat, bok);
    if (all_set) begin
      chk(fr == ev, "R7 full-turn victim", fr, ev);
      chk(lat == N + 1, "R7 full-turn latency", lat, N + 1);
    end else if (wr) begin
      chk(fr == ev, "R6 wrapped victim", fr, ev);
    end else begin
      chk(fr == ev, {tag, " R5 victim"}, fr, ev);
    end
    chk(lat == sk + 1, "R4 latency", lat, sk + 1);
    chk(bok, "R3 busy window", int'(bok), 1);
    @(negedge clk);
    chk(victim_valid == 1'b0, "R11 single pulse", int'(victim_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int fr, lat, h;
    bit bok;
    for (int i = 0; i < N; i++) m_bits[i] = 1'b0;
    m_hand = 0;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk(busy == 1'b0, "R2 busy at reset", int'(busy), 0);
    chk(victim_valid == 1'b0, "R2 victim_valid at reset", int'(victim_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R3 idle without request", int'(busy), 0);
    // R2: all flags clear, hand at 0 -> first victim is frame 0 in one cycle
    evict_and_check("R2");

    // R1: one touched frame is passed over once
    touch(m_hand);
    evict_and_check("R1");

    // R8: all flags clear, next victim is the one after the last victim
    evict_and_check("R8");

    // R7: every flag high
    for (int i = 0; i < N; i++) touch(i);
    evict_and_check("R7");

    // R10: extra request during a scan is ignored
    for (int i = 0; i < N; i++) touch(i);
    h = m_hand;
    start_evict();
    @(negedge clk);
    evict_req = 1'b1;
    @(negedge clk);
    evict_req = 1'b0;
    wait_victim(fr, lat, bok);
    chk(fr == h, "R10 victim with extra request", fr, h);
    chk(lat + 2 == N + 1, "R10 scan length unchanged", lat + 2, N + 1);
    for (int i = 0; i < N; i++) m_bits[i] = 1'b0;
    m_hand = (h + 1) % N;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(victim_valid == 1'b0 && busy == 1'b0, "R10 no second scan",
          int'(victim_valid) + int'(busy), 0);
    end

    // R9: access collides with the scan clear on frame h+2
    for (int i = 0; i < N; i++) touch(i);
    h = m_hand;
    start_evict();
    @(negedge clk);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_frame = W'((h + 2) % N);
    @(negedge clk);
    acc_valid = 1'b0;
    wait_victim(fr, lat, bok);
    chk(fr == h, "R9 collision scan victim", fr, h);
    for (int i = 0; i < N; i++) m_bits[i] = 1'b0;
    m_bits[(h + 2) % N] = 1'b1;
    m_hand = (h + 1) % N;
    evict_and_check("R9");
    start_evict();
    wait_victim(fr, lat, bok);
    chk(fr == (h + 3) % N, "R9 kept flag passed over", fr, (h + 3) % N);
    chk(lat == 2, "R9 kept flag latency", lat, 2);
    m_bits[(h + 2) % N] = 1'b0;
    m_hand = (h + 4) % N;

    // Sweep of flag patterns at moving hand positions
    for (int it = 0; it < 300; it++) begin
      int pat = (it * 53 + 7) & 255;
      if ((it % 16) == 5) pat = 255;
      for (int f = 0; f < N; f++) if (pat[f]) touch(f);
      evict_and_check("sweep");
      if ((it % 7) == 3) evict_and_check("sweep back-to-back");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule